// File: doc/BRIEF.md
# Serial Ferroelectric Memory Slave

This block is a synthesizable SPI slave that behaves like a byte-addressed serial ferroelectric RAM. It sits on a system clock and oversamples the SPI pins. Each chip-select frame carries a one-byte opcode, followed by whatever that command needs. The block has no erase cycle and writes take effect at bus speed, so a host can stream data in and read it straight back.

The memory array size is a parameter and must be a power of two. The number of address bytes follows from that size: two for arrays up to 64 KiB, three above. A status register holds a write-enable latch, a 3-bit block-protect field and a status-write-protect flag. The block-protect field fences off an upper fraction of the array against writes. An identification command returns a fixed manufacturer and type signature followed by parameterised density and variant bytes.

The block works in SPI mode 3 with 8-bit transfers and MSB first. Read and write bursts continue for as long as chip select stays low. The address advances after every data byte and wraps to zero past the last location.

Top module: `fram_spi_slave`

## Requirements
- R1: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it. The latch is status bit 1.
- R2: Opcode 0x05 returns the status byte on every following byte of the frame. The layout is bit 7 status-write-protect, bits 6:5 zero, bits 4:2 block protect, bit 1 write-enable latch, and bit 0 write-in-progress. Bit 0 always reads 0. After reset the status byte is 0x00.
- R3: Opcode 0x01 with the latch set loads block protect from data bits 4:2 and the status-write-protect flag from data bit 7. With the latch clear, the status register is unchanged.
- R4: The write-enable latch reads 0 after chip select rises at the end of a frame that carried opcode 0x01 or 0x02.
- R5: Opcode 0x03 is followed by an address sent MSB first, two bytes for arrays of 64 KiB or less and three bytes above that. Data starts on the next byte and continues with an incrementing address. Address bits above the array size are ignored.
- R6: Opcode 0x0B takes the address, then exactly one dummy byte, and then returns data the same way as opcode 0x03.
- R7: Opcode 0x02 with the latch set writes each byte that follows the address, starting at that address and incrementing after each byte. With the latch clear, no byte is written.
- R8: During a read or write burst the address wraps from the last array location to 0.
- R9: Block-protect codes 0 to 7 protect, in that order, nothing, then the upper 1/64, 1/32, 1/16, 1/8, 1/4 and 1/2 of the array, then the whole array. A byte aimed at a protected address is not stored, and the address still advances.
- R10: Opcode 0x9F returns six 0x7F bytes, then 0xC2, then the density byte, then the variant byte, and then 0x00 for the rest of the frame.
- R11: Input bits are taken on rising SCLK edges and MISO changes only after falling SCLK edges or chip-select changes, MSB first. MISO is 0 after reset, while deselected and during the opcode byte.
- R12: An unrecognised opcode leaves the rest of the frame without effect: MISO stays 0 and no state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock, idles high (mode 3) |
| spi_cs_n | input | 1 | Active-low chip select that frames one command |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |

## Verification
The hardest situation to reach from the pins is a single write burst that crosses from an unprotected into a protected region while the address keeps advancing. The stimulus first raises block protect through an enabled status write. It then starts a write one byte below the fence and reads the span back, so that the unchanged bytes inside the fence and the stored byte below it appear in one read. The same pattern is repeated with the whole array protected and with the upper half protected. A burst that crosses the array end checks the address wrap.

// File: rtl/fram_pkg.sv
package fram_pkg;
   localparam logic [7:0] CMD_WEN_SET   = 8'h06;
   localparam logic [7:0] CMD_WEN_CLR   = 8'h04;
   localparam logic [7:0] CMD_STAT_RD   = 8'h05;
   localparam logic [7:0] CMD_STAT_WR   = 8'h01;
   localparam logic [7:0] CMD_DATA_RD   = 8'h03;
   localparam logic [7:0] CMD_DATA_FRD  = 8'h0B;
   localparam logic [7:0] CMD_DATA_WR   = 8'h02;
   localparam logic [7:0] CMD_IDENT     = 8'h9F;

   localparam logic [7:0] SIG_CONT      = 8'h7F;
   localparam logic [7:0] SIG_KIND      = 8'hC2;
   localparam int         SIG_CONT_CNT  = 6;

   typedef enum logic [3:0] {
      PH_OPCODE,
      PH_ADDR,
      PH_DUMMY,
      PH_RD_DATA,
      PH_WR_DATA,
      PH_STAT_WR,
      PH_STAT_RD,
      PH_IDENT,
      PH_IDLE
   } phase_e;
endpackage

// File: rtl/fram_spi_phy.sv
module fram_spi_phy #(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sclk_i,
   input  logic       cs_n_i,
   input  logic       mosi_i,
   input  logic [7:0] tx_byte_i,
   output logic       miso_o,
   output logic       frame_start_o,
   output logic       frame_end_o,
   output logic       rx_valid_o,
   output logic [7:0] rx_byte_o
);
   localparam int LAST = SYNC_STAGES - 1;

   // {sclk, cs_n, mosi} through a synchroniser chain
   logic [2:0] sync_q [SYNC_STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q[0] <= 3'b110;
      else        sync_q[0] <= {sclk_i, cs_n_i, mosi_i};
   end

   for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q[s] <= 3'b110;
         else        sync_q[s] <= sync_q[s-1];
      end
   end

   logic sclk_s, cs_s, mosi_s;
   logic sclk_d, cs_d;
   assign sclk_s = sync_q[LAST][2];
   assign cs_s   = sync_q[LAST][1];
   assign mosi_s = sync_q[LAST][0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d <= 1'b1;
         cs_d   <= 1'b1;
      end else begin
         sclk_d <= sclk_s;
         cs_d   <= cs_s;
      end
   end

   logic rise_ev, fall_ev, cs_fall, cs_rise;
   assign rise_ev = sclk_s & ~sclk_d & ~cs_s;
   assign fall_ev = ~sclk_s & sclk_d & ~cs_s;
   assign cs_fall = ~cs_s & cs_d;
   assign cs_rise = cs_s & ~cs_d;

   logic [2:0] bit_cnt;
   logic [7:0] rx_sr, tx_sr;
   logic       rx_vld_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt  <= '0;
         rx_sr    <= '0;
         tx_sr    <= '0;
         rx_vld_q <= 1'b0;
      end else begin
         rx_vld_q <= 1'b0;
         if (cs_fall) begin
            bit_cnt <= '0;
            tx_sr   <= '0;
         end else if (cs_rise) begin
            tx_sr   <= '0;
         end else begin
            if (rise_ev) begin
               rx_sr   <= {rx_sr[6:0], mosi_s};
               bit_cnt <= bit_cnt + 3'd1;
               if (bit_cnt == 3'd7) rx_vld_q <= 1'b1;
            end
            if (fall_ev) begin
               if (bit_cnt == 3'd0) tx_sr <= tx_byte_i;
               else                 tx_sr <= {tx_sr[6:0], 1'b0};
            end
         end
      end
   end

   assign miso_o        = tx_sr[7];
   assign rx_valid_o    = rx_vld_q;
   assign rx_byte_o     = rx_sr;
   assign frame_start_o = cs_fall;
   assign frame_end_o   = cs_rise;

   // R11: output bit moves only after a falling SCLK or a select change
   p_miso_edge_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(miso_o) |-> $past(fall_ev || cs_fall || cs_rise));

   // R11: a full byte is reported only after eight rising edges
   p_byte_after_rise_r11: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid_o |-> $past(rise_ev));
endmodule

// File: rtl/fram_protect.sv
module fram_protect #(
   parameter int AW = 10
) (
   input  logic [AW-1:0] addr_i,
   input  logic [2:0]    bp_i,
   output logic          prot_o
);
   logic [7:0] hit;

   assign hit[0] = 1'b0;
   assign hit[7] = 1'b1;

   // code c guards the upper 1/2^(7-c): the top (7-c) address bits all ones
   for (genvar c = 1; c < 7; c++) begin : g_code
      localparam int TOPB = 7 - c;
      assign hit[c] = &addr_i[AW-1 -: TOPB];
   end

   assign prot_o = hit[bp_i];
endmodule

// File: rtl/fram_store.sv
module fram_store #(
   parameter int DEPTH          = 1024,
   parameter int AW             = 10,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we_i,
   input  logic [AW-1:0] addr_i,
   input  logic [7:0]    wdata_i,
   output logic [7:0]    rdata_o
);
   logic [7:0] cells [DEPTH];

   if (CLEAR_ON_RESET) begin : g_clear
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= 8'h00;
         end else if (we_i) begin
            cells[addr_i] <= wdata_i;
         end
      end
   end else begin : g_plain
      always_ff @(posedge clk) begin
         if (we_i) cells[addr_i] <= wdata_i;
      end
   end

   assign rdata_o = cells[addr_i];
endmodule

// File: rtl/fram_ctrl.sv
module fram_ctrl
   import fram_pkg::*;
#(
   parameter int         AW         = 10,
   parameter int         ADDR_BYTES = 2,
   parameter logic [7:0] DENSITY    = 8'h22,
   parameter logic [7:0] VARIANT    = 8'h00
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          frame_start_i,
   input  logic          frame_end_i,
   input  logic          rx_valid_i,
   input  logic [7:0]    rx_byte_i,
   input  logic [7:0]    mem_rdata_i,
   input  logic          prot_i,
   output logic [7:0]    tx_byte_o,
   output logic          mem_we_o,
   output logic [AW-1:0] mem_addr_o,
   output logic [7:0]    mem_wdata_o,
   output logic [2:0]    bp_o
);
   localparam logic [1:0] ACNT_LAST = 2'(ADDR_BYTES - 1);
   localparam logic [AW-1:0] ADDR_TOP = '1;

   phase_e        phase;
   logic [7:0]    cmd_q;
   logic [1:0]    acnt;
   logic [AW-1:0] addr_q;
   logic [3:0]    id_idx;
   logic          wel, srwd, drop_wel;
   logic [2:0]    bp;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= PH_IDLE;
         cmd_q    <= '0;
         acnt     <= '0;
         addr_q   <= '0;
         id_idx   <= '0;
         wel      <= 1'b0;
         srwd     <= 1'b0;
         bp       <= '0;
         drop_wel <= 1'b0;
      end else if (frame_start_i) begin
         phase  <= PH_OPCODE;
         acnt   <= '0;
         id_idx <= '0;
      end else if (frame_end_i) begin
         if (drop_wel) wel <= 1'b0;
         drop_wel <= 1'b0;
         phase    <= PH_IDLE;
      end else if (rx_valid_i) begin
         unique case (phase)
            PH_OPCODE: begin
               cmd_q <= rx_byte_i;
               case (rx_byte_i)
                  CMD_WEN_SET: begin wel <= 1'b1; phase <= PH_IDLE; end
                  CMD_WEN_CLR: begin wel <= 1'b0; phase <= PH_IDLE; end
                  CMD_STAT_RD: phase <= PH_STAT_RD;
                  CMD_STAT_WR: begin
                     drop_wel <= 1'b1;
                     phase    <= wel ? PH_STAT_WR : PH_IDLE;
                  end
                  CMD_DATA_RD, CMD_DATA_FRD: phase <= PH_ADDR;
                  CMD_DATA_WR: begin
                     drop_wel <= 1'b1;
                     phase    <= wel ? PH_ADDR : PH_IDLE;
                  end
                  CMD_IDENT: phase <= PH_IDENT;
                  default:   phase <= PH_IDLE;
               endcase
            end
            PH_ADDR: begin
               addr_q <= AW'({addr_q, rx_byte_i});
               acnt   <= acnt + 2'd1;
               if (acnt == ACNT_LAST) begin
                  if (cmd_q == CMD_DATA_FRD)     phase <= PH_DUMMY;
                  else if (cmd_q == CMD_DATA_WR) phase <= PH_WR_DATA;
                  else                           phase <= PH_RD_DATA;
               end
            end
            PH_DUMMY:   phase  <= PH_RD_DATA;
            PH_RD_DATA: addr_q <= addr_q + AW'(1);
            PH_WR_DATA: addr_q <= addr_q + AW'(1);
            PH_STAT_WR: begin
               bp    <= rx_byte_i[4:2];
               srwd  <= rx_byte_i[7];
               phase <= PH_IDLE;
            end
            PH_IDENT:   if (id_idx != 4'hF) id_idx <= id_idx + 4'd1;
            default: ;
         endcase
      end
   end

   logic [7:0] ident_byte;
   always_comb begin
      if (id_idx < 4'(SIG_CONT_CNT))            ident_byte = SIG_CONT;
      else if (id_idx == 4'(SIG_CONT_CNT))      ident_byte = SIG_KIND;
      else if (id_idx == 4'(SIG_CONT_CNT + 1))  ident_byte = DENSITY;
      else if (id_idx == 4'(SIG_CONT_CNT + 2))  ident_byte = VARIANT;
      else                                      ident_byte = 8'h00;
   end

   always_comb begin
      case (phase)
         PH_STAT_RD: tx_byte_o = {srwd, 2'b00, bp, wel, 1'b0};
         PH_RD_DATA: tx_byte_o = mem_rdata_i;
         PH_IDENT:   tx_byte_o = ident_byte;
         default:    tx_byte_o = 8'h00;
      endcase
   end

   assign mem_we_o    = (phase == PH_WR_DATA) && rx_valid_i && !prot_i
                        && !frame_start_i && !frame_end_i;
   assign mem_addr_o  = addr_q;
   assign mem_wdata_o = rx_byte_i;
   assign bp_o        = bp;

   // R3: protection settings cannot move while the latch is clear
   p_bp_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !wel |=> ($stable(bp) && $stable(srwd)));

   // R4: a frame with a write or status write leaves the latch cleared
   p_wel_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_end_i && drop_wel) |=> !wel);

   // R7: the array is only written while the latch is set
   p_we_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we_o |-> wel);

   // R8: the burst address wraps to zero past the top location
   p_addr_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid_i && !frame_start_i && !frame_end_i
       && (phase == PH_RD_DATA || phase == PH_WR_DATA)
       && addr_q == ADDR_TOP) |=> (addr_q == '0));
endmodule

// File: rtl/fram_spi_slave.sv
module fram_spi_slave #(
   parameter int         MEM_BYTES      = 1024,
   parameter logic [7:0] DENSITY_CODE   = 8'h22,
   parameter logic [7:0] VARIANT_CODE   = 8'h00,
   parameter int         SYNC_STAGES    = 2,
   parameter bit         CLEAR_ON_RESET = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic spi_sclk,
   input  logic spi_cs_n,
   input  logic spi_mosi,
   output logic spi_miso
);
   localparam int AW         = $clog2(MEM_BYTES);
   localparam int ADDR_BYTES = (MEM_BYTES > 65536) ? 3 : 2;

   if (MEM_BYTES < 64) begin : g_chk_small
      $error("MEM_BYTES must be at least 64");
   end
   if ((1 << AW) != MEM_BYTES) begin : g_chk_pow2
      $error("MEM_BYTES must be a power of two");
   end
   if (AW > 24) begin : g_chk_big
      $error("MEM_BYTES exceeds a 3-byte address");
   end
   if (SYNC_STAGES < 2) begin : g_chk_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic          frame_start, frame_end, rx_valid;
   logic [7:0]    rx_byte, tx_byte, mem_rdata, mem_wdata;
   logic          mem_we, prot;
   logic [AW-1:0] mem_addr;
   logic [2:0]    bp;

   fram_spi_phy #(.SYNC_STAGES(SYNC_STAGES)) u_phy (
      .clk           (clk),
      .rst_n         (rst_n),
      .sclk_i        (spi_sclk),
      .cs_n_i        (spi_cs_n),
      .mosi_i        (spi_mosi),
      .tx_byte_i     (tx_byte),
      .miso_o        (spi_miso),
      .frame_start_o (frame_start),
      .frame_end_o   (frame_end),
      .rx_valid_o    (rx_valid),
      .rx_byte_o     (rx_byte)
   );

   fram_ctrl #(
      .AW         (AW),
      .ADDR_BYTES (ADDR_BYTES),
      .DENSITY    (DENSITY_CODE),
      .VARIANT    (VARIANT_CODE)
   ) u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .frame_start_i (frame_start),
      .frame_end_i   (frame_end),
      .rx_valid_i    (rx_valid),
      .rx_byte_i     (rx_byte),
      .mem_rdata_i   (mem_rdata),
      .prot_i        (prot),
      .tx_byte_o     (tx_byte),
      .mem_we_o      (mem_we),
      .mem_addr_o    (mem_addr),
      .mem_wdata_o   (mem_wdata),
      .bp_o          (bp)
   );

   fram_protect #(.AW(AW)) u_prot (
      .addr_i (mem_addr),
      .bp_i   (bp),
      .prot_o (prot)
   );

   fram_store #(
      .DEPTH          (MEM_BYTES),
      .AW             (AW),
      .CLEAR_ON_RESET (CLEAR_ON_RESET)
   ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (mem_we),
      .addr_i  (mem_addr),
      .wdata_i (mem_wdata),
      .rdata_o (mem_rdata)
   );

   // R9: no store lands inside the protected region
   p_we_unprot_r9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> !prot);
endmodule

// File: tb/fram_spi_slave_tb.sv
module fram_spi_slave_tb;
   localparam int DEPTH = 1024;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic spi_sclk = 1'b1;
   logic spi_cs_n = 1'b1;
   logic spi_mosi = 1'b0;
   logic spi_miso;

   always #5 clk = ~clk;

   fram_spi_slave u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .spi_sclk (spi_sclk),
      .spi_cs_n (spi_cs_n),
      .spi_mosi (spi_mosi),
      .spi_miso (spi_miso)
   );

   int total = 0;
   int bad   = 0;
   bit ended = 1'b0;

   // reference model state
   logic [7:0] m_mem [DEPTH];
   logic [2:0] m_bp   = 3'd0;
   logic       m_srwd = 1'b0;
   logic       m_wel  = 1'b0;

   // scoreboard
   logic [7:0] exp_q [$];
   bit         care_q [$];
   string      tag_q [$];
   logic [7:0] rx_last;
   event       byte_done;

   initial begin
      forever begin
         @(byte_done);
         if (exp_q.size() != 0) begin
            logic [7:0] e;
            bit c;
            string t;
            e = exp_q.pop_front();
            c = care_q.pop_front();
            t = tag_q.pop_front();
            if (c) begin
               total++;
               if (rx_last !== e) begin
                  bad++;
                  $display("FAIL %s: got %02h expected %02h", t, rx_last, e);
               end
            end
         end
      end
   end

   function automatic logic [7:0] m_status();
      return {m_srwd, 2'b00, m_bp, m_wel, 1'b0};
   endfunction

   function automatic bit m_prot(input int a);
      if (m_bp == 3'd0) return 1'b0;
      if (m_bp == 3'd7) return 1'b1;
      return a >= (DEPTH - (DEPTH >> (7 - m_bp)));
   endfunction

   task automatic cs_lo();
      @(negedge clk) spi_cs_n = 1'b0;
      repeat (8) @(negedge clk);
   endtask

   task automatic cs_hi();
      repeat (8) @(negedge clk);
      spi_cs_n = 1'b1;
      repeat (12) @(negedge clk);
   endtask

   task automatic xb(input logic [7:0] mo, input logic [7:0] ex, input bit care, input string tag);
      logic [7:0] got;
      exp_q.push_back(ex);
      care_q.push_back(care);
      tag_q.push_back(tag);
      for (int b = 7; b >= 0; b--) begin
         spi_sclk = 1'b0;
         spi_mosi = mo[b];
         repeat (8) @(negedge clk);
         got[b] = spi_miso;
         spi_sclk = 1'b1;
         repeat (8) @(negedge clk);
      end
      rx_last = got;
      -> byte_done;
      @(negedge clk);
   endtask

   task automatic single(input logic [7:0] op);
      cs_lo();
      xb(op, 8'h00, 1'b1, "R11 opcode byte");
      cs_hi();
   endtask

   task automatic wren();
      single(8'h06);
      m_wel = 1'b1;
   endtask

   task automatic wrdi();
      single(8'h04);
      m_wel = 1'b0;
   endtask

   task automatic rdsr(input int n, input string tag);
      cs_lo();
      xb(8'h05, 8'h00, 1'b1, "R11 opcode byte");
      for (int i = 0; i < n; i++) xb(8'h00, m_status(), 1'b1, tag);
      cs_hi();
   endtask

   task automatic wrsr(input logic [7:0] v);
      cs_lo();
      xb(8'h01, 8'h00, 1'b1, "R11 opcode byte");
      xb(v, 8'h00, 1'b0, "");
      cs_hi();
      if (m_wel) begin
         m_bp   = v[4:2];
         m_srwd = v[7];
      end
      m_wel = 1'b0;
   endtask

   task automatic cmd_write(input logic [15:0] a, input int n, input logic [31:0] d);
      cs_lo();
      xb(8'h02, 8'h00, 1'b1, "R11 opcode byte");
      xb(a[15:8], 8'h00, 1'b0, "");
      xb(a[7:0], 8'h00, 1'b0, "");
      for (int i = 0; i < n; i++) begin
         logic [7:0] v;
         int ad;
         v  = d[31-8*i -: 8];
         ad = (int'(a) + i) % DEPTH;
         xb(v, 8'h00, 1'b0, "");
         if (m_wel && !m_prot(ad)) m_mem[ad] = v;
      end
      cs_hi();
      m_wel = 1'b0;
   endtask

   task automatic cmd_read(input logic [15:0] a, input int n, input bit fast, input string tag);
      cs_lo();
      xb(fast ? 8'h0B : 8'h03, 8'h00, 1'b1, "R11 opcode byte");
      xb(a[15:8], 8'h00, 1'b0, "");
      xb(a[7:0], 8'h00, 1'b0, "");
      if (fast) xb(8'hA5, 8'h00, 1'b0, "");
      for (int i = 0; i < n; i++) xb(8'h00, m_mem[(int'(a) + i) % DEPTH], 1'b1, tag);
      cs_hi();
   endtask

   initial begin
      for (int i = 0; i < DEPTH; i++) m_mem[i] = 8'h00;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      total++;
      if (spi_miso !== 1'b0) begin
         bad++;
         $display("FAIL R11 reset miso: got %0b expected 0", spi_miso);
      end

      rdsr(3, "R2 status after reset");
      wren();
      rdsr(1, "R1 latch set");
      wrdi();
      rdsr(1, "R1 latch cleared");

      cmd_write(16'h0010, 2, 32'hAABB0000);
      cmd_read(16'h0010, 2, 1'b0, "R7 write without latch ignored");

      wren();
      cmd_write(16'h0010, 4, 32'h11223344);
      rdsr(1, "R4 latch dropped after write");
      cmd_read(16'h0010, 4, 1'b0, "R5 read burst");
      cmd_read(16'h0410, 2, 1'b0, "R5 upper address bits ignored");
      cmd_read(16'h0011, 3, 1'b1, "R6 fast read after dummy");

      wren();
      cmd_write(16'h03FE, 3, 32'h5A6B7C00);
      cmd_read(16'h03FE, 3, 1'b0, "R8 wrap past array end");

      wrsr(8'h9C);
      rdsr(1, "R3 status write without latch ignored");
      wren();
      wrsr(8'h84);
      rdsr(2, "R3 status write / R4 latch dropped");

      wren();
      cmd_write(16'h03EF, 3, 32'hD0D1D200);
      cmd_read(16'h03EF, 3, 1'b0, "R9 upper 1/64 protected");

      wren();
      wrsr(8'h1C);
      wren();
      cmd_write(16'h0000, 1, 32'hEE000000);
      cmd_read(16'h0000, 1, 1'b0, "R9 whole array protected");

      wren();
      wrsr(8'h18);
      wren();
      cmd_write(16'h01FF, 2, 32'h12340000);
      cmd_read(16'h01FF, 2, 1'b0, "R9 upper half protected");

      cs_lo();
      xb(8'h9F, 8'h00, 1'b1, "R11 opcode byte");
      for (int i = 0; i < 6; i++) xb(8'h00, 8'h7F, 1'b1, "R10 continuation byte");
      xb(8'h00, 8'hC2, 1'b1, "R10 type byte");
      xb(8'h00, 8'h22, 1'b1, "R10 density byte");
      xb(8'h00, 8'h00, 1'b1, "R10 variant byte");
      xb(8'h00, 8'h00, 1'b1, "R10 trailing zero");
      xb(8'h00, 8'h00, 1'b1, "R10 trailing zero");
      cs_hi();

      cs_lo();
      xb(8'hAB, 8'h00, 1'b1, "R11 opcode byte");
      xb(8'h06, 8'h00, 1'b1, "R12 unknown opcode miso");
      xb(8'hFF, 8'h00, 1'b1, "R12 unknown opcode miso");
      cs_hi();
      rdsr(1, "R12 state unchanged");
      cmd_read(16'h01FF, 1, 1'b0, "R12 memory unchanged");

      total++;
      if (spi_miso !== 1'b0) begin
         bad++;
         $display("FAIL R11 idle miso: got %0b expected 0", spi_miso);
      end

      if (!ended) begin
         ended = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!ended) begin
         ended = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule